// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers for a clock generator. A host loads the bank with a fixed block-write sequence and reads it back with a block-read. There is no register addressing. After the device address, every write carries a command byte and a count byte. The slave acknowledges both and discards them. Data bytes then fill the bank from byte 0 upward, and each byte takes effect as soon as it completes. A read returns a count byte followed by the whole bank in order.

While the power-on reset is low, the block samples a 5-bit strap vector. The strap pins are shared with clock outputs elsewhere on the chip. The block stores the inverted levels in the low five bits of the last register, and software cannot change that field. The bank drives several outputs: a frequency-select code, taken either from the straps or from register 0, a spread-spectrum enable, a tristate-all control and a vector of per-output enables. The bus inputs are sampled with a system clock that must run at least 8 times faster than SCL. SDA is driven open-drain through a pull-low control.

Top module: `scfg_slave`

## Requirements
- R1: After reset, register 0 reads 0x00 and registers 1 to 4 read 0xFF. The upper three bits of register 5 are 1. `outEnable` is all ones, `spreadEn`, `tristateAll` and `freqFromReg` are 0, and SDA is released.
- R2: While reset is low, the strap vector is captured inverted into register 5 bits 4:0. Bit 4 is the mode strap and bits 3:0 are the frequency straps. `modeStrap` shows the captured mode level. Strap changes after reset have no effect.
- R3: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address gets no acknowledge and leaves every register unchanged.
- R4: In a write, the slave acknowledges the command byte and the count byte and discards both. The following data bytes are stored into registers 0, 1, 2 and onward, and every byte is acknowledged. Bytes past register 5 are acknowledged and dropped.
- R5: A stop after any complete data byte keeps the bytes written so far and leaves the remaining registers unchanged.
- R6: In a read, the slave sends a count byte of 6 and then registers 0 to 5, MSB first. It changes SDA only while SCL is low.
- R7: A host non-acknowledge during a read ends the transfer. SDA stays released afterwards, even if SCL keeps toggling.
- R8: When register 0 bit 3 is 0, `freqCode` is {0, strap levels 3:0}. When it is 1, `freqCode` is {register 0 bit 2, register 0 bits 7:4}.
- R9: `spreadEn` follows register 0 bit 1 and `tristateAll` follows register 0 bit 0. Both change only after a completed data byte.
- R10: Writes to register 5 update only bits 7:5. Bits 4:0 keep the captured strap value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Power-on reset, active low, synchronous; straps are sampled while low |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain) |
| strapIn | input | 5 | Strap levels: bit 4 mode, bits 3:0 frequency select |
| freqCode | output | 5 | Effective frequency-select code |
| freqFromReg | output | 1 | 1 when the code comes from register 0 |
| spreadEn | output | 1 | Spread-spectrum enable |
| tristateAll | output | 1 | Tristate all clock outputs |
| modeStrap | output | 1 | Captured mode strap level |
| outEnable | output | 35 | Output enables: registers 1 to 4, then register 5 bits 7:5 on top |

## Verification
The bench probes how the discarded command and count bytes line up with register 0. A slave that is off by one would place the command value in register 0, and the frequency code would show it. It writes past the end of the bank and into the strap field. A wrong design would let the extra byte wrap into register 0, or it would overwrite the inverted straps, which then read back as the written value. It sends a foreign address followed by data that must leave the bank untouched. It also ends reads early with a non-acknowledge and then keeps clocking. A slave that misses the non-acknowledge would keep pulling SDA low on later pulses.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // Register index width; covers banks of up to 12 bytes with saturation headroom.
  localparam int IDX_W   = 4;
  localparam int STRAP_W = 5;
  localparam int FREQ_W  = 5;

  typedef enum logic [1:0] {DRV_NONE, DRV_ACK, DRV_DATA} drive_e;

  typedef struct packed {
    logic             shiftIn;    // sample SDA into the receive shifter
    logic             commit;     // store received byte into register regIdx
    logic             loadTx;     // load transmit shifter
    logic             loadCount;  // with loadTx: send the byte count instead of a register
    logic             shiftTx;    // advance transmit shifter by one bit
    logic [IDX_W-1:0] regIdx;
  } strobe_t;
endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int         NUM_BYTES = 6,
  parameter logic [6:0] DEV_ADDR  = 7'h69
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclRise,
  input  logic    sclFall,
  input  logic    busStart,
  input  logic    busStop,
  input  logic    sdaS,
  input  logic [7:0] rxByte,
  output strobe_t stb,
  output drive_e  drive
);
  localparam int CNT_W = $clog2(NUM_BYTES + 4);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_BYTES + 3);
  localparam logic [CNT_W-1:0] WR_BASE = CNT_W'(3);   // address, command, count precede data
  localparam logic [CNT_W-1:0] RD_BASE = CNT_W'(1);   // address precedes the count byte
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(NUM_BYTES);

  typedef enum logic [2:0] {PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK} phase_e;

  phase_e           phase;
  logic [3:0]       bitCnt;
  logic [CNT_W-1:0] byteNum;
  logic [CNT_W-1:0] byteNext;
  logic [CNT_W-1:0] wrIdx;
  logic             isRead;
  logic             byteDone;

  assign byteNext = (byteNum == CNT_MAX) ? byteNum : byteNum + 1'b1;
  assign wrIdx    = byteNum - WR_BASE;
  assign byteDone = (bitCnt == 4'd8);

  always_comb begin
    stb = '0;
    stb.shiftIn = (phase == PH_RX) && sclRise && !byteDone;
    stb.commit  = (phase == PH_RX) && sclFall && byteDone && !isRead &&
                  (byteNum >= WR_BASE) && (wrIdx < LIMIT);
    stb.loadTx    = sclFall && ((phase == PH_RXACK && isRead) || phase == PH_TXACK);
    stb.loadCount = (phase == PH_RXACK);
    stb.shiftTx   = (phase == PH_TX) && sclFall && !byteDone;
    if (phase == PH_TXACK) stb.regIdx = IDX_W'(byteNum - RD_BASE);
    else                   stb.regIdx = IDX_W'(wrIdx);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      byteNum <= '0;
      isRead  <= 1'b0;
      drive   <= DRV_NONE;
    end else if (busStart) begin
      phase   <= PH_RX;
      bitCnt  <= '0;
      byteNum <= '0;
      isRead  <= 1'b0;
      drive   <= DRV_NONE;
    end else if (busStop) begin
      phase <= PH_IDLE;
      drive <= DRV_NONE;
    end else begin
      case (phase)
        PH_RX: begin
          if (sclRise && !byteDone) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            if (byteNum == '0 && rxByte[7:1] != DEV_ADDR) begin
              phase <= PH_IDLE;
            end else begin
              phase <= PH_RXACK;
              drive <= DRV_ACK;
              if (byteNum == '0) isRead <= rxByte[0];
            end
          end
        end
        PH_RXACK: begin
          if (sclFall) begin
            bitCnt  <= '0;
            byteNum <= byteNext;
            if (isRead) begin
              phase <= PH_TX;
              drive <= DRV_DATA;
            end else begin
              phase <= PH_RX;
              drive <= DRV_NONE;
            end
          end
        end
        PH_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            phase <= PH_TXACK;
            drive <= DRV_NONE;
          end
        end
        PH_TXACK: begin
          if (sclRise) begin
            if (sdaS) phase <= PH_IDLE;    // host non-acknowledge ends the read
          end else if (sclFall) begin
            phase   <= PH_TX;
            drive   <= DRV_DATA;
            bitCnt  <= '0;
            byteNum <= byteNext;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/scfg_datapath.sv
module scfg_datapath
  import scfg_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int EN_W      = 8 * (NUM_BYTES - 2) + (8 - STRAP_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapIn,
  input  strobe_t            stb,
  input  drive_e             drive,
  output logic               sclS,
  output logic               sdaS,
  output logic               sclRise,
  output logic               sclFall,
  output logic               busStart,
  output logic               busStop,
  output logic [7:0]         rxByte,
  output logic               sdaDriveLow,
  output logic [FREQ_W-1:0]  freqCode,
  output logic               freqFromReg,
  output logic               spreadEn,
  output logic               tristateAll,
  output logic               modeStrap,
  output logic [EN_W-1:0]    outEnable
);
  localparam int LAST = NUM_BYTES - 1;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic [7:0] rxShift, txShift, txNext;
  logic [7:0] cfgReg [NUM_BYTES];

  // Two-stage synchronizers and edge history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign busStart = sclS && sclPrev && sdaPrev && !sdaS;
  assign busStop  = sclS && sclPrev && !sdaPrev && sdaS;
  assign rxByte   = rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) rxShift <= '0;
    else if (stb.shiftIn) rxShift <= {rxShift[6:0], sdaS};
  end

  // Register bank; straps are captured inverted while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_BYTES; k++) cfgReg[k] <= (k == 0) ? 8'h00 : 8'hFF;
      cfgReg[LAST] <= {{(8 - STRAP_W){1'b1}}, ~strapIn};
    end else if (stb.commit) begin
      for (int k = 0; k < NUM_BYTES; k++) begin
        if (stb.regIdx == IDX_W'(k)) begin
          if (k == LAST) cfgReg[k][7:STRAP_W] <= rxShift[7:STRAP_W];
          else           cfgReg[k] <= rxShift;
        end
      end
    end
  end

  always_comb begin
    txNext = 8'hFF;
    if (stb.loadCount) begin
      txNext = 8'(NUM_BYTES);
    end else begin
      for (int k = 0; k < NUM_BYTES; k++)
        if (stb.regIdx == IDX_W'(k)) txNext = cfgReg[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) txShift <= 8'hFF;
    else if (stb.loadTx) txShift <= txNext;
    else if (stb.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end

  assign sdaDriveLow = (drive == DRV_ACK) || (drive == DRV_DATA && !txShift[7]);

  // Decoded configuration
  assign freqFromReg = cfgReg[0][3];
  assign spreadEn    = cfgReg[0][1];
  assign tristateAll = cfgReg[0][0];
  assign modeStrap   = ~cfgReg[LAST][4];
  assign freqCode    = freqFromReg ? {cfgReg[0][2], cfgReg[0][7:4]}
                                   : {1'b0, ~cfgReg[LAST][3:0]};

  for (genvar g = 1; g < LAST; g++) begin : g_en
    assign outEnable[8*(g-1) +: 8] = cfgReg[g];
  end
  assign outEnable[EN_W-1 -: (8 - STRAP_W)] = cfgReg[LAST][7:STRAP_W];
endmodule

// File: rtl/scfg_slave.sv
module scfg_slave
  import scfg_pkg::*;
#(
  parameter int         NUM_BYTES = 6,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         EN_W      = 8 * (NUM_BYTES - 2) + (8 - STRAP_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaDriveLow,
  input  logic [STRAP_W-1:0] strapIn,
  output logic [FREQ_W-1:0]  freqCode,
  output logic               freqFromReg,
  output logic               spreadEn,
  output logic               tristateAll,
  output logic               modeStrap,
  output logic [EN_W-1:0]    outEnable
);
  strobe_t    stb;
  drive_e     drive;
  logic       sclS, sdaS, sclRise, sclFall, busStart, busStop;
  logic [7:0] rxByte;

  scfg_ctrl #(.NUM_BYTES(NUM_BYTES), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .busStart(busStart), .busStop(busStop), .sdaS(sdaS), .rxByte(rxByte),
    .stb(stb), .drive(drive)
  );

  scfg_datapath #(.NUM_BYTES(NUM_BYTES), .EN_W(EN_W)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapIn(strapIn),
    .stb(stb), .drive(drive), .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise),
    .sclFall(sclFall), .busStart(busStart), .busStop(busStop), .rxByte(rxByte),
    .sdaDriveLow(sdaDriveLow), .freqCode(freqCode), .freqFromReg(freqFromReg),
    .spreadEn(spreadEn), .tristateAll(tristateAll), .modeStrap(modeStrap),
    .outEnable(outEnable)
  );
endmodule

// File: rtl/scfg_slave_chk.sv
module scfg_slave_chk
  import scfg_pkg::*;
#(
  parameter int NUM_BYTES = 6
) (
  input logic    clk,
  input logic    rstN,
  input logic    sclS,
  input logic    sdaDriveLow,
  input strobe_t stb,
  input logic    tristateAll,
  input logic    spreadEn,
  input logic    modeStrap
);
  // R6: slave never moves SDA while SCL is high
  assert_sda_quiet_scl_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaDriveLow));

  // R4: a register store always targets a register inside the bank
  assert_commit_in_bank_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> (int'(stb.regIdx) < NUM_BYTES));

  // R6: store, load and shift never coincide
  assert_strobe_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.commit, stb.loadTx, stb.shiftTx}));

  // R9: control bits move only after a completed data byte
  assert_ctl_bits_on_commit_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.commit) |-> ($stable(tristateAll) && $stable(spreadEn)));

  // R2: captured mode strap is frozen once reset is released
  assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(modeStrap));
endmodule

bind scfg_slave scfg_slave_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .sdaDriveLow(sdaDriveLow), .stb(stb),
  .tristateAll(tristateAll), .spreadEn(spreadEn), .modeStrap(modeStrap)
);

// File: tb/scfg_slave_tb.sv
module scfg_slave_tb;
  localparam int Q = 10;  // clocks per quarter SCL period

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        scl = 1'b1;
  logic        sdaHost = 1'b1;
  logic        sdaLine;
  logic        sdaDriveLow;
  logic [4:0]  strapIn = 5'b10110;
  logic [4:0]  freqCode;
  logic        freqFromReg, spreadEn, tristateAll, modeStrap;
  logic [34:0] outEnable;
  int          testCount = 0;
  int          failCount = 0;

  always #4 clk = ~clk;   // 125 MHz

  assign sdaLine = sdaHost & ~sdaDriveLow;

  scfg_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow),
    .strapIn(strapIn), .freqCode(freqCode), .freqFromReg(freqFromReg),
    .spreadEn(spreadEn), .tristateAll(tristateAll), .modeStrap(modeStrap),
    .outEnable(outEnable)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaHost = 1'b1; scl = 1'b1; waitClk(Q);
    sdaHost = 1'b0; waitClk(Q);
    scl = 1'b0; waitClk(Q);
  endtask

  task automatic busStop();
    sdaHost = 1'b0; waitClk(Q);
    scl = 1'b1; waitClk(Q);
    sdaHost = 1'b1; waitClk(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaHost = b[i]; waitClk(Q);
      scl = 1'b1; waitClk(2 * Q);
      scl = 1'b0; waitClk(Q);
    end
    sdaHost = 1'b1; waitClk(Q);
    scl = 1'b1; waitClk(Q);
    acked = !sdaLine;
    waitClk(Q);
    scl = 1'b0; waitClk(Q);
  endtask

  task automatic recvByte(input bit hostAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdaHost = 1'b1; waitClk(Q);
      scl = 1'b1; waitClk(Q);
      b[i] = sdaLine;
      waitClk(Q);
      scl = 1'b0; waitClk(Q);
    end
    sdaHost = hostAck ? 1'b0 : 1'b1; waitClk(Q);
    scl = 1'b1; waitClk(2 * Q);
    scl = 1'b0; waitClk(Q);
    sdaHost = 1'b1;
  endtask

  task automatic testReset();
    check(freqFromReg == 1'b0, "R1 freqFromReg", 64'(freqFromReg), 0);
    check(spreadEn == 1'b0, "R1 spreadEn", 64'(spreadEn), 0);
    check(tristateAll == 1'b0, "R1 tristateAll", 64'(tristateAll), 0);
    check(outEnable == {35{1'b1}}, "R1 outEnable", 64'(outEnable), 64'h7_FFFF_FFFF);
    check(sdaDriveLow == 1'b0, "R1 sda released", 64'(sdaDriveLow), 0);
    check(modeStrap == 1'b1, "R2 modeStrap", 64'(modeStrap), 1);
    check(freqCode == 5'b00110, "R8 strap freqCode", 64'(freqCode), 64'h06);
  endtask

  task automatic readAll(input logic [7:0] exp [7], input string tag);
    bit ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, ack);
    check(ack, {tag, " R3 read address ack"}, 64'(ack), 1);
    for (int k = 0; k < 7; k++) begin
      recvByte(k != 6, b);
      check(b == exp[k], $sformatf("%s R6 read byte %0d", tag, k), 64'(b), 64'(exp[k]));
    end
    waitClk(Q);
    check(sdaDriveLow == 1'b0, {tag, " R7 released after nack"}, 64'(sdaDriveLow), 0);
    busStop();
  endtask

  task automatic testReadDefaults();
    logic [7:0] exp [7] = '{8'h06, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hE9};
    readAll(exp, "defaults R1 R2");
  endtask

  task automatic testForeignAddress();
    bit ack;
    busStart();
    sendByte(8'hA0, ack);
    check(!ack, "R3 foreign address nack", 64'(ack), 0);
    sendByte(8'h00, ack);
    sendByte(8'h00, ack);
    sendByte(8'h0B, ack);
    busStop();
    check(tristateAll == 1'b0 && spreadEn == 1'b0, "R3 no change tristate/spread",
          64'({tristateAll, spreadEn}), 0);
    check(freqFromReg == 1'b0, "R3 no change freqFromReg", 64'(freqFromReg), 0);
  endtask

  task automatic testPartialWrite();
    bit ack;
    bit allAck = 1'b1;
    busStart();
    sendByte(8'hD2, ack); allAck &= ack;
    sendByte(8'h55, ack); allAck &= ack;   // command, discarded
    sendByte(8'h77, ack); allAck &= ack;   // count, discarded
    sendByte(8'hAE, ack); allAck &= ack;
    sendByte(8'h0F, ack); allAck &= ack;
    busStop();
    check(allAck, "R4 all bytes acked", 64'(allAck), 1);
    check(freqCode == 5'b11010, "R8 register freqCode", 64'(freqCode), 64'h1A);
    check(freqFromReg == 1'b1, "R8 freqFromReg", 64'(freqFromReg), 1);
    check(spreadEn == 1'b1, "R9 spreadEn", 64'(spreadEn), 1);
    check(tristateAll == 1'b0, "R9 tristateAll", 64'(tristateAll), 0);
    check(outEnable[7:0] == 8'h0F, "R4 byte1 stored", 64'(outEnable[7:0]), 64'h0F);
    check(outEnable[34:8] == {27{1'b1}}, "R5 later bytes unchanged",
          64'(outEnable[34:8]), 64'h7FF_FFFF);
  endtask

  task automatic testFullWrite();
    bit ack;
    bit allAck = 1'b1;
    logic [7:0] data [7] = '{8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h99};
    logic [7:0] exp [7] = '{8'h06, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44, 8'h09};
    strapIn = 5'b00000;   // after reset: must be ignored
    busStart();
    sendByte(8'hD2, ack); allAck &= ack;
    sendByte(8'hC3, ack); allAck &= ack;
    sendByte(8'h06, ack); allAck &= ack;
    for (int k = 0; k < 7; k++) begin
      sendByte(data[k], ack); allAck &= ack;
    end
    busStop();
    check(allAck, "R4 overflow byte acked", 64'(allAck), 1);
    check(tristateAll == 1'b1, "R9 tristate set", 64'(tristateAll), 1);
    check(freqCode == 5'b00110, "R2 R8 straps frozen", 64'(freqCode), 64'h06);
    check(modeStrap == 1'b1, "R2 mode frozen", 64'(modeStrap), 1);
    check(outEnable == 35'h0_4433_2211, "R10 enables", 64'(outEnable), 64'h0_4433_2211);
    readAll(exp, "full R10");
  endtask

  task automatic testEarlyNack();
    bit ack;
    logic [7:0] b;
    bit anyLow = 1'b0;
    busStart();
    sendByte(8'hD3, ack);
    recvByte(1'b0, b);
    check(b == 8'h06, "R6 count byte", 64'(b), 64'h06);
    for (int i = 0; i < 9; i++) begin
      waitClk(Q); scl = 1'b1; waitClk(Q);
      anyLow |= sdaDriveLow;
      waitClk(Q); scl = 1'b0; waitClk(Q);
      anyLow |= sdaDriveLow;
    end
    check(!anyLow, "R7 no drive after nack", 64'(anyLow), 0);
    busStop();
  endtask

  initial begin
    waitClk(10);
    rstN = 1'b1;
    waitClk(10);
    testReset();
    testReadDefaults();
    testForeignAddress();
    testPartialWrite();
    testFullWrite();
    testEarlyNack();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule